// File: doc/BRIEF.md
# Four-Digit Decimal Stopwatch Counter

This block counts hundredths of a second as a four-digit decimal value. It holds each decimal digit in its own 4-bit register and outputs all of them packed into one 16-bit word, which a separate seven-segment display driver can read. A free-running prescaler runs on the system clock. Every 2^PRESCALE_BITS cycles it produces a one-cycle tick, which is about 1/100 s when PRESCALE_BITS is 20 and the clock is near 100 MHz. Every flip-flop uses the single system clock, and the slow rate reaches the digits only as a clock enable.

A two-state machine sets whether a tick advances the count. The states are ST_HALT and ST_COUNT. Transition T_START goes from ST_HALT to ST_COUNT when `run` is high at a clock edge. Transition T_STOP goes from ST_COUNT to ST_HALT when `run` is low at a clock edge. The machine only gates the tick, so the prescaler keeps its phase across a pause. A tick taken in ST_COUNT always steps the lowest digit. It steps each higher digit only when every digit below that one holds nine. A synchronous `clr` zeroes the digits and leaves the prescaler and the state machine alone.

Top module: `bcd_stopwatch`

## Requirements
- R1: Each 4-bit digit field of `count_bcd` always holds a value from 0 to 9. Digit 0, the least significant, is bits [3:0]. Digit 1 is bits [7:4], digit 2 is bits [11:8] and digit 3 is bits [15:12].
- R2: On an advance, digit 0 goes from 9 to 0, or otherwise increases by one.
- R3: On an advance, a higher digit changes only if every lower digit is 9. It then wraps from 9 to 0 or increases by one. Otherwise it keeps its value.
- R4: An advance from 9999 gives 0000.
- R5: The prescaler ticks on every 2^PRESCALE_BITS-th clock edge after reset is released. The first tick falls on edge number 2^PRESCALE_BITS.
- R6: Between advances, `count_bcd` holds its value.
- R7: `run` is sampled into the state machine at every edge, and a tick advances the count only when the state is ST_COUNT before that edge. A pause does not reset the prescaler phase.
- R8: `clr` high at an edge makes `count_bcd` zero after that edge. It takes priority over an advance at the same edge and leaves the prescaler phase unchanged.
- R9: `rst` high at an edge zeroes the digits and the prescaler, and puts the state machine in ST_HALT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High lets prescaler ticks advance the count |
| clr | input | 1 | Synchronous clear of the digits, active high |
| count_bcd | output | 4*NUM_DIGITS | Packed decimal digits, digit 0 in the lowest nibble |

## Verification
The hardest case to reach is the full carry through every digit, from 9999 to 0000. It needs ten thousand ticks, and at the production prescaler width those would take billions of cycles. The bench sets the prescaler width to 3, so a tick comes every 8 cycles. It then walks the count through all 10000 values and compares each one with a decimal conversion of a plain integer. That covers every 0999-to-1000-style carry and the final wrap. Pause and clear are placed at chosen prescaler phases, so a tick can be seen both suppressed and kept in phase.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int DIG_W = 4;
    typedef logic [DIG_W-1:0] bcd_t;
    localparam bcd_t BCD_TOP = 4'd9;
    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
    parameter int BITS = 20
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    // counter full: the wrap edge is the tick edge
    assign tick = &cnt_q;
endmodule

// File: rtl/sw_run_fsm.sv
module sw_run_fsm
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic adv
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run)  state_d = ST_COUNT;  // T_START
            ST_COUNT: if (!run) state_d = ST_HALT;   // T_STOP
            default:            state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALT;
        else     state_q <= state_d;
    end

    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            ST_HALT:  adv = 1'b0;
            ST_COUNT: adv = tick;
            default:  adv = 1'b0;
        endcase
    end
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output bcd_t digit,
    output logic at_top
);
    bcd_t val_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            val_q <= '0;
        else if (inc)
            val_q <= (val_q == BCD_TOP) ? bcd_t'(0) : val_q + 1'b1;
    end

    assign digit  = val_q;
    assign at_top = (val_q == BCD_TOP);
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
    import sw_pkg::*;
#(
    parameter int PRESCALE_BITS = 20,
    parameter int NUM_DIGITS    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run,
    input  logic                        clr,
    output logic [DIG_W*NUM_DIGITS-1:0] count_bcd
);
    logic tick;
    logic adv;
    logic [NUM_DIGITS:0]   carry;
    logic [NUM_DIGITS-1:0] top_flag;

    sw_prescaler #(.BITS(PRESCALE_BITS)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sw_run_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .adv  (adv)
    );

    assign carry[0] = adv;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        bcd_t dval;
        sw_bcd_digit u_dig (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .inc    (carry[g]),
            .digit  (dval),
            .at_top (top_flag[g])
        );
        // enable ripples upward only through digits sitting at nine
        assign carry[g+1] = carry[g] & top_flag[g];
        assign count_bcd[g*DIG_W +: DIG_W] = dval;
    end
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
    parameter int NUM_DIGITS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clr,
    input logic                    adv,
    input logic [4*NUM_DIGITS-1:0] count_bcd
);
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_rng
        AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
            count_bcd[g*4 +: 4] <= 4'd9);  // R1
    end

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (count_bcd[3:0] ==
            (($past(count_bcd[3:0]) == 4'd9) ? 4'd0 : $past(count_bcd[3:0]) + 4'd1)));  // R2

    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && count_bcd[3:0] != 4'd9) |=>
            $stable(count_bcd[4*NUM_DIGITS-1:4]));  // R3

    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && count_bcd == {NUM_DIGITS{4'd9}}) |=> (count_bcd == '0));  // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(count_bcd));  // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_bcd == '0));  // R8
endmodule

bind bcd_stopwatch sw_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .adv       (adv),
    .count_bcd (count_bcd)
);

// File: tb/sim_bcd_stopwatch.sv
module sim_bcd_stopwatch;
    localparam int PB  = 3;
    localparam int PER = 1 << PB;

    typedef struct packed {
        logic        run;
        logic        clr;
        logic [15:0] cyc;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    // walked from reset release with run low during reset
    localparam vec_t VECS [9] = '{
        '{1'b1, 1'b0, 16'd8,   16'h0001, 8'd5},  // R5 first tick at edge 8
        '{1'b1, 1'b0, 16'd80,  16'h0011, 8'd3},  // R3 carry into digit 1
        '{1'b0, 1'b0, 16'd8,   16'h0011, 8'd7},  // R7 halted tick suppressed
        '{1'b1, 1'b0, 16'd4,   16'h0011, 8'd6},  // R6 holds mid period
        '{1'b1, 1'b0, 16'd4,   16'h0012, 8'd7},  // R7 phase kept after pause
        '{1'b1, 1'b1, 16'd1,   16'h0000, 8'd8},  // R8 clear
        '{1'b1, 1'b0, 16'd3,   16'h0000, 8'd8},  // R8 prescaler not reset
        '{1'b1, 1'b0, 16'd4,   16'h0001, 8'd8},  // R8 tick stays on phase
        '{1'b1, 1'b0, 16'd792, 16'h0100, 8'd2}   // R2 R3 99 ticks
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] count_bcd;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bcd_stopwatch #(.PRESCALE_BITS(PB), .NUM_DIGITS(4)) u0 (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .clr       (clr),
        .count_bcd (count_bcd)
    );

    function automatic logic [15:0] to_bcd(input int n);
        return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (count_bcd !== exp) begin
            fails++;
            $display("FAIL %s count=%h expected=%h", req, count_bcd, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog count=%h expected=done", count_bcd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        edges(3);
        check("R9", 16'h0000);
        rst = 1'b0;

        foreach (VECS[i]) begin
            run = VECS[i].run;
            clr = VECS[i].clr;
            edges(int'(VECS[i].cyc));
            clr = 1'b0;
            check($sformatf("R%0d", VECS[i].req), VECS[i].exp);
        end

        // R8 clear while halted
        run = 1'b0;
        edges(2);
        clr = 1'b1;
        edges(1);
        clr = 1'b0;
        check("R8", 16'h0000);

        // full sweep after a fresh reset: R2 R3 R4
        rst = 1'b1;
        edges(1);
        check("R9", 16'h0000);
        rst = 1'b0;
        run = 1'b1;
        for (int n = 1; n <= 10000; n++) begin
            edges(PER);
            if (n == 10000)      check("R4", to_bcd(0));
            else if (n % 10 == 0) check("R3", to_bcd(n));
            else                  check("R2", to_bcd(n));
        end

        // R9 R5 reset in the middle of a period restarts the prescaler
        edges(3);
        rst = 1'b1;
        edges(1);
        check("R9", 16'h0000);
        rst = 1'b0;
        edges(PER - 1);
        check("R5", 16'h0000);
        edges(1);
        check("R5", 16'h0001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule